// File: doc/BRIEF.md
# Quadrature and Pulse-Direction Decoder

This block turns the raw A, B and index lines of one encoder channel into the strobes that drive a position counter. It produces a one-clock count-up or count-down enable, a direction level and an index-load strobe. The counter register and any bus access sit outside the block. All three inputs pass through a synchroniser chain into the system clock domain. Edges are then found by comparing the synchronised value with the value one clock older.

A two-bit mode input selects how edges become counts. The modes are pulse/direction and three quadrature resolutions, at one, two or four counts per cycle of the encoder. The index line can be active high or active low. It issues a load strobe only when the preset option is on. A synchronous option also requires both A and B to be low when the index edge arrives, and this option has effect only in the quadrature modes. In quadrature modes, a sample where A and B change together is counted as an error and raises a sticky flag.

Top module: `quad_decoder`

## Requirements
- R1: With mode = 2'b00 (pulse/direction), each rising edge of synchronised A produces one count, up when B is high and down when B is low. Falling A edges and B changes produce no count, and `dir` follows B.
- R2: With mode = 2'b01 (x1), a full encoder cycle produces exactly one count. A forward cycle counts on the rising edge of A and a backward cycle counts on the falling edge of A.
- R3: With mode = 2'b10 (x2), every edge of A produces one count, and B edges produce none.
- R4: With mode = 2'b11 (x4), every single edge of A or B produces one count.
- R5: In quadrature modes, forward means the (A,B) sequence 00, 10, 11, 01, so A leads B. Forward steps count up and set `dir` high. The reverse order counts down and sets `dir` low.
- R6: `count_up` and `count_dn` are never high together. A high `count_up` implies `dir` is high, and a high `count_dn` implies `dir` is low.
- R7: With `preset_en` high, an active index edge gives one `idx_load` pulse. The active edge is the rising edge when `idx_pol` = 1 and the falling edge of the raw input when `idx_pol` = 0.
- R8: With `preset_en` low, the index line never produces `idx_load`.
- R9: In a quadrature mode with `idx_sync_req` high, `sync_active` is high. An index edge then loads only while synchronised A and B are both low.
- R10: In pulse/direction mode, `idx_sync_req` is ignored. `sync_active` stays low and index edges load whatever the levels of A and B.
- R11: In a quadrature mode, a sample where A and B both change sets `noise_err` and produces no count. The flag stays set until `err_clr` is pulsed.
- R12: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 1 | Raw encoder A (pulse in pulse/direction mode) |
| b_in | input | 1 | Raw encoder B (direction in pulse/direction mode) |
| idx_in | input | 1 | Raw index line |
| mode | input | 2 | 00 pulse/direction, 01 x1, 10 x2, 11 x4 |
| idx_pol | input | 1 | 1: index active high, 0: active low |
| idx_sync_req | input | 1 | Request A/B gating of the index |
| preset_en | input | 1 | Allow index edges to issue load strobes |
| err_clr | input | 1 | Clears the noise flag |
| count_up | output | 1 | One-clock count-up enable |
| count_dn | output | 1 | One-clock count-down enable |
| dir | output | 1 | 1 counting up, 0 counting down |
| idx_load | output | 1 | One-clock load strobe from the index |
| noise_err | output | 1 | Sticky illegal-transition flag |
| sync_active | output | 1 | Synchronous index gating in force |

## Verification
The bench builds the decoder with the default two-stage synchroniser. It counts strobes over windows long enough to absorb that latency, so the checks depend on the number of counts per encoder cycle and not on the cycle in which each count appears. Each mode is driven forward and backward through whole Gray-code cycles, and simultaneous A/B changes are injected. Index pulses are applied under both polarities, with the preset option off, and with synchronous gating held at and away from the A=B=0 state.

// File: rtl/quad_decoder.sv
module quad_decoder #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_in,
  input  logic       b_in,
  input  logic       idx_in,
  input  logic [1:0] mode,
  input  logic       idx_pol,
  input  logic       idx_sync_req,
  input  logic       preset_en,
  input  logic       err_clr,
  output logic       count_up,
  output logic       count_dn,
  output logic       dir,
  output logic       idx_load,
  output logic       noise_err,
  output logic       sync_active
);
  localparam logic [1:0] M_PD = 2'b00;
  localparam logic [1:0] M_X1 = 2'b01;
  localparam logic [1:0] M_X2 = 2'b10;
  localparam int         TOP  = SYNC_STAGES - 1;

  logic [TOP:0] a_sh, b_sh, i_sh;
  logic a_p, b_p, i_p;
  logic a_s, b_s, i_s;
  logic a_chg, b_chg, one, both, fwd, quad, hit, go_up, idx_edge, gate;

  // synchronisers, SYNC_STAGES >= 2
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_sh <= '0;
      b_sh <= '0;
      i_sh <= '0;
      a_p  <= 1'b0;
      b_p  <= 1'b0;
      i_p  <= 1'b0;
    end else begin
      a_sh <= {a_sh[TOP-1:0], a_in};
      b_sh <= {b_sh[TOP-1:0], b_in};
      i_sh <= {i_sh[TOP-1:0], idx_in};
      a_p  <= a_s;
      b_p  <= b_s;
      i_p  <= i_s;
    end

  assign a_s   = a_sh[TOP];
  assign b_s   = b_sh[TOP];
  assign i_s   = i_sh[TOP];
  assign a_chg = a_s ^ a_p;
  assign b_chg = b_s ^ b_p;
  assign one   = a_chg ^ b_chg;
  assign both  = a_chg & b_chg;
  assign fwd   = a_chg ? (a_s ^ b_s) : (a_s ~^ b_s);
  assign quad  = (mode != M_PD);

  always_comb begin
    go_up = fwd;
    case (mode)
      M_PD: begin
        hit   = a_chg & a_s;
        go_up = b_s;
      end
      M_X1:    hit = one & a_chg & (fwd ? a_s : ~a_s);
      M_X2:    hit = one & a_chg;
      default: hit = one;
    endcase
  end

  assign sync_active = idx_sync_req & quad;
  assign idx_edge    = idx_pol ? (i_s & ~i_p) : (~i_s & i_p);
  assign gate        = ~sync_active | (~a_s & ~b_s);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count_up  <= 1'b0;
      count_dn  <= 1'b0;
      dir       <= 1'b0;
      idx_load  <= 1'b0;
      noise_err <= 1'b0;
    end else begin
      count_up <= hit & go_up;
      count_dn <= hit & ~go_up;
      idx_load <= preset_en & idx_edge & gate;
      if (!quad)
        dir <= b_s;
      else if (one)
        dir <= fwd;
      if (quad & both)
        noise_err <= 1'b1;
      else if (err_clr)
        noise_err <= 1'b0;
    end
endmodule

// File: rtl/quad_decoder_chk.sv
module quad_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       preset_en,
  input logic       err_clr,
  input logic       count_up,
  input logic       count_dn,
  input logic       dir,
  input logic       idx_load,
  input logic       noise_err,
  input logic       sync_active
);
  AST_UPDN_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(count_up && count_dn)); // R6
  AST_UP_DIR: assert property (@(posedge clk) disable iff (!rst_n) count_up |-> dir); // R6
  AST_DN_DIR: assert property (@(posedge clk) disable iff (!rst_n) count_dn |-> !dir); // R6
  AST_NO_LOAD_OFF: assert property (@(posedge clk) disable iff (!rst_n) !preset_en |=> !idx_load); // R8
  AST_PD_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'b00) |-> !sync_active); // R10
  AST_NOISE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (noise_err && !err_clr) |=> noise_err); // R11
endmodule

bind quad_decoder quad_decoder_chk i_chk (.*);

// File: tb/test_quad_decoder.sv
module test_quad_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic a_in = 0, b_in = 0, idx_in = 0;
  logic [1:0] mode = 2'b00;
  logic idx_pol = 1, idx_sync_req = 0, preset_en = 0, err_clr = 0;
  logic count_up, count_dn, dir, idx_load, noise_err, sync_active;
  int n_up = 0, n_dn = 0, n_ld = 0;
  int b_up, b_dn, b_ld;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  quad_decoder i_quad_decoder (.*);

  always @(negedge clk) if (rst_n) begin
    if (count_up) n_up++;
    if (count_dn) n_dn++;
    if (idx_load) n_ld++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic snap();
    @(negedge clk);
    b_up = n_up; b_dn = n_dn; b_ld = n_ld;
  endtask

  task automatic step(input logic a, input logic b);
    @(negedge clk);
    a_in = a; b_in = b;
    repeat (5) @(negedge clk);
  endtask

  task automatic idx_pulse(input logic active);
    @(negedge clk); idx_in = active;
    repeat (5) @(negedge clk);
    idx_in = ~active;
    repeat (5) @(negedge clk);
  endtask

  task automatic fwd_cycle(); step(1,0); step(1,1); step(0,1); step(0,0); endtask
  task automatic bwd_cycle(); step(0,1); step(1,1); step(1,0); step(0,0); endtask

  task automatic t_reset();
    chk("R12 count_up", count_up, 0);
    chk("R12 count_dn", count_dn, 0);
    chk("R12 dir", dir, 0);
    chk("R12 idx_load", idx_load, 0);
    chk("R12 noise_err", noise_err, 0);
    chk("R12 sync_active", sync_active, 0);
  endtask

  task automatic t_pd();
    mode = 2'b00;
    step(0,1);
    chk("R1 dir follows B", dir, 1);
    snap();
    repeat (3) begin step(1,1); step(0,1); end
    chk("R1 up counts", n_up - b_up, 3);
    chk("R1 no down", n_dn - b_dn, 0);
    step(0,0);
    chk("R1 dir low", dir, 0);
    snap();
    repeat (2) begin step(1,0); step(0,0); end
    chk("R1 down counts", n_dn - b_dn, 2);
    chk("R1 no up", n_up - b_up, 0);
  endtask

  task automatic t_quad(input logic [1:0] m, input int per, input string tag);
    mode = m;
    snap();
    repeat (2) fwd_cycle();
    chk({tag, " fwd up"}, n_up - b_up, 2*per);
    chk({tag, " fwd no dn"}, n_dn - b_dn, 0);
    chk("R5 dir fwd", dir, 1);
    snap();
    repeat (2) bwd_cycle();
    chk({tag, " bwd dn"}, n_dn - b_dn, 2*per);
    chk({tag, " bwd no up"}, n_up - b_up, 0);
    chk("R5 dir bwd", dir, 0);
  endtask

  task automatic t_noise();
    mode = 2'b11;
    snap();
    step(1,1);
    chk("R11 flag set", noise_err, 1);
    chk("R11 no count", (n_up - b_up) + (n_dn - b_dn), 0);
    repeat (10) @(negedge clk);
    chk("R11 sticky", noise_err, 1);
    err_clr = 1; @(negedge clk); err_clr = 0;
    @(negedge clk);
    chk("R11 cleared", noise_err, 0);
    step(0,1); step(0,0);
    chk("R11 single steps clean", noise_err, 0);
  endtask

  task automatic t_index();
    mode = 2'b11; preset_en = 1; idx_pol = 1; idx_sync_req = 0;
    snap(); idx_pulse(1);
    chk("R7 positive load", n_ld - b_ld, 1);
    idx_pol = 0;
    snap(); idx_pulse(1);
    chk("R7 negative load", n_ld - b_ld, 1);
    idx_pol = 1; preset_en = 0;
    snap(); idx_pulse(1);
    chk("R8 disabled no load", n_ld - b_ld, 0);
    preset_en = 1; idx_sync_req = 1;
    @(negedge clk);
    chk("R9 sync active", sync_active, 1);
    step(1,0);
    snap(); idx_pulse(1);
    chk("R9 gated off", n_ld - b_ld, 0);
    step(0,0);
    snap(); idx_pulse(1);
    chk("R9 gated on", n_ld - b_ld, 1);
  endtask

  task automatic t_pd_sync();
    mode = 2'b00; idx_sync_req = 1; preset_en = 1; idx_pol = 1;
    step(1,1);
    chk("R10 sync inactive", sync_active, 0);
    snap(); idx_pulse(1);
    chk("R10 loads ungated", n_ld - b_ld, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_pd();
    t_quad(2'b01, 1, "R2 x1");
    t_quad(2'b10, 2, "R3 x2");
    t_quad(2'b11, 4, "R4 x4");
    t_noise();
    t_index();
    t_pd_sync();
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule